// File: doc/BRIEF.md
# Banked Vectored Interrupt Controller

This block collects a set of interrupt sources and presents one winner at a time to a processor. The sources are grouped into banks of 32 lines. Vector `v` sits in bank `v/32` at bit `v%32`. Each bank has three mask registers: a plain mask, a write-one-to-set alias and a write-one-to-clear alias. Each bank also has a software-trigger register with its own set and clear aliases. Each vector has a line register that holds a priority and an output route. A global threshold filters out low-urgency lines.

The highest-priority line that is pending, unmasked and allowed by the threshold wins. Its vector is latched and `irq_out` or `fiq_out` rises. The latched vector stays frozen until software writes an acknowledge bit. The next arbitration for that output starts only after that write. A soft-reset command restores every register to its power-up value.

Access goes through a simple word-addressed register bus. Writes take effect at the clock edge. Read data appears one cycle after the read strobe.

Top module: `vec_intc`

## Requirements
- R1: After reset, every mask bit reads 1 (mask at word 0x10+8*b). Every software-trigger bit reads 0 (word 0x13+8*b). The threshold (word 0x03) reads 0xFF, every line register (word 0x80+v) reads 0, the status word (0x01) reads 1, and both outputs are low.
- R2: Writing to the mask-set alias (0x11+8*b) sets each mask bit whose data bit is 1. Writing to the mask-clear alias (0x12+8*b) clears each mask bit whose data bit is 1. Bits written as 0 keep their value.
- R3: A source whose mask bit is 1 never wins. With source `v` the only unmasked active line, the IRQ active-vector word (0x04) reads `v` in bits 6:0. Vector `v` is controlled by bank `v/32`, bit `v%32`.
- R4: Writing 1s to the software-set alias (0x14+8*b) makes those lines pending exactly like a raised source input. Writing 1s to the software-clear alias (0x15+8*b) removes them.
- R5: The line register holds the priority in bits 7:2, and a smaller value means more urgent. The most urgent eligible line wins. On equal priority, the lowest vector number wins.
- R6: When the threshold is not 0xFF, a line is eligible only if its priority is strictly less than the threshold. A threshold of 0xFF disables this filter.
- R7: Bit 0 of a line register selects the output: 0 for `irq_out`, 1 for `fiq_out`. The FIQ winner is reported in word 0x05.
- R8: Once an output is raised, it stays high and its reported vector stays fixed until acknowledged. This holds even if the source drops or a more urgent line arrives.
- R9: Writing the control word (0x02) with bit 0 set drops `irq_out` at that edge. With bit 1 set it drops `fiq_out`. A new winner can be latched on the following edge.
- R10: Writing the system-config word (0x00) with bit 1 set triggers a soft reset that restores the R1 state. Status bit 0 then reads 1 again.
- R11: Read data for the word addressed in a cycle with `bus_re` high appears on `bus_rdata` after that clock edge. Unused words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_in | input | 96 | Raw interrupt source levels |
| irq_out | output | 1 | Normal interrupt request |
| fiq_out | output | 1 | Fast interrupt request |

## Verification
Suppose a mask, software-trigger or line register holds the wrong bit. The output then rises for a line that should be blocked, or stays low for one that should win. The active-vector word exposes the wrong winner on the first read after the request rises. A latch that fails to hold would show up as a changed vector word between acknowledges. A missed acknowledge would leave the output high on the edge after the control write. Every such fault becomes visible within one or two cycles of the stimulus that exposes it.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int REG_SYSCFG  = 0;
  localparam int REG_SYSSTAT = 1;
  localparam int REG_CTRL    = 2;
  localparam int REG_THRESH  = 3;
  localparam int REG_ACT_IRQ = 4;
  localparam int REG_ACT_FIQ = 5;
  localparam int BANK_BASE   = 16;
  localparam int BANK_STRIDE = 8;
  localparam int OFS_MASK    = 0;
  localparam int OFS_MSET    = 1;
  localparam int OFS_MCLR    = 2;
  localparam int OFS_SWI     = 3;
  localparam int OFS_SSET    = 4;
  localparam int OFS_SCLR    = 5;
  localparam int LINE_BASE   = 128;
endpackage

// File: rtl/vic_bank.sv
module vic_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mask_we,
  input  logic         mset_we,
  input  logic         mclr_we,
  input  logic         sset_we,
  input  logic         sclr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask,
  output logic [W-1:0] swi
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= '1;
      swi  <= '0;
    end else begin
      if (mask_we) mask <= wdata;
      else if (mset_we) mask <= mask | wdata;
      else if (mclr_we) mask <= mask & ~wdata;
      if (sset_we) swi <= swi | wdata;
      else if (sclr_we) swi <= swi & ~wdata;
    end
  end

  AST_MASK_SET_ONES: assert property (@(posedge clk) disable iff (rst)
    (mset_we && !mask_we) |=> ((mask & $past(wdata)) == $past(wdata))); // R2
  AST_MASK_CLR_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (mclr_we && !mask_we && !mset_we) |=> ((mask & ~$past(wdata)) == ($past(mask) & ~$past(wdata)))); // R2
  AST_SWI_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (sclr_we && !sset_we) |=> ((swi & $past(wdata)) == '0)); // R4
endmodule

// File: rtl/vic_arb.sv
module vic_arb #(
  parameter int NSRC   = 96,
  parameter int PRIO_W = 6,
  parameter int VEC_W  = 7
) (
  input  logic [NSRC-1:0]             elig,
  input  logic [NSRC-1:0][PRIO_W-1:0] prio,
  output logic                        found,
  output logic [VEC_W-1:0]            vec
);
  logic [PRIO_W-1:0] best;

  always_comb begin
    found = 1'b0;
    vec   = '0;
    best  = '1;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i] && (prio[i] <= best)) begin
        found = 1'b1;
        best  = prio[i];
        vec   = VEC_W'(i);
      end
    end
  end
endmodule

// File: rtl/vec_intc.sv
module vec_intc
  import vic_pkg::*;
#(
  parameter int NBANK  = 3,
  parameter int BANK_W = 32,
  parameter int PRIO_W = 6,
  parameter int VEC_W  = 7,
  parameter int THR_W  = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int NSRC  = NBANK * BANK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NSRC-1:0]   src_in,
  output logic              irq_out,
  output logic              fiq_out
);
  localparam int IDX_W = ADDR_W - 1;

  function automatic logic at(input logic [ADDR_W-1:0] a, input int r);
    return a == ADDR_W'(r);
  endfunction

  logic srst_q, core_rst;
  logic [THR_W-1:0] thr_q;
  logic [NSRC-1:0][PRIO_W-1:0] prio_q;
  logic [NSRC-1:0] route_q;
  logic [NBANK-1:0][BANK_W-1:0] mask_b, swi_b;
  logic [NSRC-1:0] mask_all, swi_all, pending, pass, elig_irq, elig_fiq;
  logic irq_found, fiq_found, irq_q, fiq_q, ack_irq, ack_fiq;
  logic [VEC_W-1:0] irq_win, fiq_win, irq_vec, fiq_vec;
  logic line_hit;
  logic [IDX_W-1:0] line_idx;
  logic [DATA_W-1:0] rd_mux;

  assign core_rst = rst | srst_q;
  assign ack_irq  = bus_we && at(bus_addr, REG_CTRL) && bus_wdata[0];
  assign ack_fiq  = bus_we && at(bus_addr, REG_CTRL) && bus_wdata[1];
  assign line_idx = bus_addr[IDX_W-1:0];
  assign line_hit = bus_addr[ADDR_W-1] && (int'(line_idx) < NSRC);

  always_ff @(posedge clk) begin
    if (rst) srst_q <= 1'b0;
    else     srst_q <= bus_we && at(bus_addr, REG_SYSCFG) && bus_wdata[1] && !srst_q;
  end

  always_ff @(posedge clk) begin
    if (core_rst) thr_q <= '1;
    else if (bus_we && at(bus_addr, REG_THRESH)) thr_q <= bus_wdata[THR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (core_rst) begin
      prio_q  <= '0;
      route_q <= '0;
    end else if (bus_we && line_hit) begin
      prio_q[line_idx]  <= bus_wdata[PRIO_W+1:2];
      route_q[line_idx] <= bus_wdata[0];
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam int BA = BANK_BASE + b * BANK_STRIDE;
    vic_bank #(.W(BANK_W)) u_bank (
      .clk     (clk),
      .rst     (core_rst),
      .mask_we (bus_we && at(bus_addr, BA + OFS_MASK)),
      .mset_we (bus_we && at(bus_addr, BA + OFS_MSET)),
      .mclr_we (bus_we && at(bus_addr, BA + OFS_MCLR)),
      .sset_we (bus_we && at(bus_addr, BA + OFS_SSET)),
      .sclr_we (bus_we && at(bus_addr, BA + OFS_SCLR)),
      .wdata   (bus_wdata[BANK_W-1:0]),
      .mask    (mask_b[b]),
      .swi     (swi_b[b])
    );
  end

  assign mask_all = mask_b;
  assign swi_all  = swi_b;
  assign pending  = (src_in | swi_all) & ~mask_all;

  for (genvar i = 0; i < NSRC; i++) begin : g_pass
    assign pass[i] = (thr_q == '1) || (THR_W'(prio_q[i]) < thr_q);
  end

  assign elig_irq = pending & pass & ~route_q;
  assign elig_fiq = pending & pass & route_q;

  vic_arb #(.NSRC(NSRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W)) u_arb_irq (
    .elig(elig_irq), .prio(prio_q), .found(irq_found), .vec(irq_win));
  vic_arb #(.NSRC(NSRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W)) u_arb_fiq (
    .elig(elig_fiq), .prio(prio_q), .found(fiq_found), .vec(fiq_win));

  always_ff @(posedge clk) begin
    if (core_rst) begin
      irq_q <= 1'b0; irq_vec <= '0;
      fiq_q <= 1'b0; fiq_vec <= '0;
    end else begin
      if (ack_irq) irq_q <= 1'b0;
      else if (!irq_q && irq_found) begin
        irq_q <= 1'b1; irq_vec <= irq_win;
      end
      if (ack_fiq) fiq_q <= 1'b0;
      else if (!fiq_q && fiq_found) begin
        fiq_q <= 1'b1; fiq_vec <= fiq_win;
      end
    end
  end

  assign irq_out = irq_q;
  assign fiq_out = fiq_q;

  always_comb begin
    rd_mux = '0;
    if (at(bus_addr, REG_SYSSTAT)) rd_mux = DATA_W'(!srst_q);
    if (at(bus_addr, REG_THRESH))  rd_mux = DATA_W'(thr_q);
    if (at(bus_addr, REG_ACT_IRQ)) rd_mux = DATA_W'(irq_vec);
    if (at(bus_addr, REG_ACT_FIQ)) rd_mux = DATA_W'(fiq_vec);
    for (int b = 0; b < NBANK; b++) begin
      if (at(bus_addr, BANK_BASE + b * BANK_STRIDE + OFS_MASK)) rd_mux = DATA_W'(mask_b[b]);
      if (at(bus_addr, BANK_BASE + b * BANK_STRIDE + OFS_SWI))  rd_mux = DATA_W'(swi_b[b]);
    end
    if (line_hit) rd_mux = DATA_W'({prio_q[line_idx], 1'b0, route_q[line_idx]});
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_mux;
  end

  always_comb begin
    if (!core_rst && irq_found) begin
      AST_IRQ_WIN_UNMASKED: assert (!mask_all[irq_win] && !route_q[irq_win]); // R3
      AST_IRQ_WIN_THRESH: assert (thr_q == '1 || THR_W'(prio_q[irq_win]) < thr_q); // R6
    end
    if (!core_rst && fiq_found) begin
      AST_FIQ_WIN_ROUTED: assert (route_q[fiq_win] && !mask_all[fiq_win]); // R7
    end
  end

  AST_IRQ_VEC_FROZEN: assert property (@(posedge clk) disable iff (core_rst)
    (irq_q && $past(irq_q)) |-> $stable(irq_vec)); // R8
  AST_FIQ_VEC_FROZEN: assert property (@(posedge clk) disable iff (core_rst)
    (fiq_q && $past(fiq_q)) |-> $stable(fiq_vec)); // R8
  AST_IRQ_ACK_DROPS: assert property (@(posedge clk) disable iff (core_rst)
    (ack_irq && irq_q) |=> !irq_q); // R9
  AST_FIQ_ACK_DROPS: assert property (@(posedge clk) disable iff (core_rst)
    (ack_fiq && fiq_q) |=> !fiq_q); // R9
endmodule

// File: tb/vec_intc_test.sv
module vec_intc_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [95:0] src_in = '0;
  logic irq_out, fiq_out;
  int n_chk = 0, n_fail = 0;
  logic [31:0] d;

  always #2 clk = ~clk;

  vec_intc uut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
    .irq_out(irq_out), .fiq_out(fiq_out));

  function automatic int bank_a(input int b, input int off);
    return 16 + b * 8 + off;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] v);
    bus_we = 1'b1; bus_addr = 8'(a); bus_wdata = v;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    bus_re = 1'b1; bus_addr = 8'(a);
    @(negedge clk);
    bus_re = 1'b0;
    v = bus_rdata;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tick();
    // R1 / R11 reset state
    for (int b = 0; b < 3; b++) begin
      rd(bank_a(b, 0), d); chk("R1 mask reset", d, 32'hFFFF_FFFF);
      rd(bank_a(b, 3), d); chk("R1 swi reset", d, 32'h0);
    end
    rd(3, d);   chk("R1 threshold reset", d, 32'hFF);
    rd(1, d);   chk("R1 status reset", d, 32'h1);
    rd(128 + 77, d); chk("R1 line reset", d, 32'h0);
    rd(7, d);   chk("R11 unused word", d, 32'h0);
    chk("R1 irq low", {31'b0, irq_out}, 32'h0);
    chk("R1 fiq low", {31'b0, fiq_out}, 32'h0);

    // R3 sweep over every vector
    src_in = '1;
    tick(); tick();
    chk("R3 all masked no irq", {31'b0, irq_out}, 32'h0);
    for (int v = 0; v < 96; v++) begin
      wr(bank_a(v / 32, 2), 32'h1 << (v % 32));
      tick();
      chk("R3 irq for lone unmasked", {31'b0, irq_out}, 32'h1);
      rd(4, d); chk("R3 active vector", d, 32'(v));
      wr(bank_a(v / 32, 1), 32'h1 << (v % 32));
      wr(2, 32'h1);
      tick();
      chk("R3 remasked stays low", {31'b0, irq_out}, 32'h0);
    end

    // R5 priority and tie
    src_in = '0;
    for (int b = 0; b < 3; b++) wr(bank_a(b, 2), 32'hFFFF_FFFF);
    wr(128 + 5, 32'd12);
    wr(128 + 40, 32'd4);
    wr(128 + 70, 32'd4);
    src_in[5] = 1'b1; src_in[40] = 1'b1; src_in[70] = 1'b1;
    tick();
    chk("R5 irq raised", {31'b0, irq_out}, 32'h1);
    rd(4, d); chk("R5 tie lowest vector", d, 32'd40);

    // R8 freeze
    wr(128 + 5, 32'd0);
    src_in[40] = 1'b0;
    tick();
    chk("R8 irq held after source drop", {31'b0, irq_out}, 32'h1);
    rd(4, d); chk("R8 vector frozen", d, 32'd40);

    // R9 acknowledge and re-arbitrate
    wr(2, 32'h1);
    chk("R9 ack drops irq", {31'b0, irq_out}, 32'h0);
    tick();
    chk("R9 rearbitration", {31'b0, irq_out}, 32'h1);
    rd(4, d); chk("R5 most urgent wins", d, 32'd5);

    // R6 threshold
    src_in = '0;
    wr(2, 32'h1);
    wr(128 + 5, 32'd12);
    wr(3, 32'd1);
    src_in[5] = 1'b1; src_in[70] = 1'b1;
    tick(); tick();
    chk("R6 threshold blocks", {31'b0, irq_out}, 32'h0);
    wr(3, 32'd2);
    tick();
    chk("R6 threshold passes", {31'b0, irq_out}, 32'h1);
    rd(4, d); chk("R6 passing vector", d, 32'd70);
    src_in = '0;
    wr(2, 32'h1);
    wr(3, 32'hFF);

    // R7 FIQ routing
    wr(128 + 70, 32'd5);
    rd(128 + 70, d); chk("R7 line readback", d, 32'd5);
    src_in[40] = 1'b1; src_in[70] = 1'b1;
    tick();
    chk("R7 irq", {31'b0, irq_out}, 32'h1);
    chk("R7 fiq", {31'b0, fiq_out}, 32'h1);
    rd(5, d); chk("R7 fiq vector", d, 32'd70);
    rd(4, d); chk("R7 irq vector", d, 32'd40);
    src_in = '0;
    wr(2, 32'h3);
    chk("R9 fiq ack", {31'b0, fiq_out}, 32'h0);
    chk("R9 irq ack", {31'b0, irq_out}, 32'h0);

    // R4 software interrupts
    wr(bank_a(1, 4), 32'h2);
    tick();
    chk("R4 swi raises irq", {31'b0, irq_out}, 32'h1);
    rd(4, d); chk("R4 swi vector", d, 32'd33);
    rd(bank_a(1, 3), d); chk("R4 swi readback", d, 32'h2);
    wr(bank_a(1, 5), 32'h2);
    rd(bank_a(1, 3), d); chk("R4 swi cleared", d, 32'h0);
    wr(2, 32'h1);
    tick();
    chk("R4 no irq after clear", {31'b0, irq_out}, 32'h0);

    // R2 alias behaviour
    wr(bank_a(0, 1), 32'h0F0F_0000);
    rd(bank_a(0, 0), d); chk("R2 mask set alias", d, 32'h0F0F_0000);
    wr(bank_a(0, 2), 32'h0300_0000);
    rd(bank_a(0, 0), d); chk("R2 mask clear alias", d, 32'h0C0F_0000);
    wr(bank_a(0, 0), 32'h0000_FFFF);
    rd(bank_a(0, 0), d); chk("R2 mask direct write", d, 32'h0000_FFFF);

    // R10 soft reset
    wr(3, 32'h10);
    wr(0, 32'h2);
    tick(); tick();
    rd(1, d); chk("R10 status done", d, 32'h1);
    rd(bank_a(1, 0), d); chk("R10 mask restored", d, 32'hFFFF_FFFF);
    rd(bank_a(0, 0), d); chk("R10 mask bank0 restored", d, 32'hFFFF_FFFF);
    rd(3, d); chk("R10 threshold restored", d, 32'hFF);
    rd(128 + 70, d); chk("R10 line restored", d, 32'h0);
    chk("R10 irq low", {31'b0, irq_out}, 32'h0);

    finish_run();
  end
endmodule